// File: doc/BRIEF.md
# Lockable Device-Disable Register Control

This block keeps two host-visible registers: an 8-bit device-disable register and an 8-bit configuration register for one general-purpose pin. A 2-bit mode field inside the configuration register can put the pin into a guard role. Once that field holds binary 01, software can no longer change it. In that role the pin works as a plain, non-inverted input, and its level decides whether the device-disable register takes writes. A high level makes the register read-only. A low level leaves it fully writable.

The host side is a flat register port: an address, a write strobe, write data and combinational read data. Decoding of the bus protocol above this port is left to the parent. The guard pin is asynchronous, so it passes through a two-stage synchronizer before the block uses it. Three separate active-low synchronous resets (main power-on, standby power-on and hard reset) each return the block to its cleared state. No other event can release the guard mode.

Top module: `guard_reg_ctrl`

## Requirements
- R1: Any of the three resets (`por_n`, `stby_por_n`, `hard_rst_n`) held low at a clock edge clears both the device-disable register and the configuration register to 0x00.
- R2: While configuration bits [3:2] hold binary 01, a write to the configuration register leaves bits [3:2] at 01 and loads every other bit from the write data.
- R3: While configuration bits [3:2] hold any value other than 01, a write to the configuration register loads all eight bits, including bits [3:2].
- R4: A write to the device-disable register (address 0x22) is dropped when configuration bit 2 is 1 and the synchronized pin level is high. The register then keeps its old value.
- R5: A write to the device-disable register takes effect when the synchronized pin level is low or configuration bit 2 is 0.
- R6: `rd_data` is combinational from `addr`. It shows the current device-disable value at 0x22 and the configuration value at 0x30, also while writes are blocked. Every other address reads 0x00, and writes to other addresses change nothing.
- R7: The pin passes through two flops before the write-block decision. A write on the first clock edge after the pin rises still uses the old low level and is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Main power-on reset, active low, synchronous |
| stby_por_n | input | 1 | Standby power-on reset, active low, synchronous |
| hard_rst_n | input | 1 | Hard reset, active low, synchronous |
| addr | input | 8 | Register address |
| wr_en | input | 1 | Write strobe, one write per asserted cycle |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` |
| guard_pin | input | 1 | External guard pin level, asynchronous |

## Verification
The assertions check four rules on every cycle:
- the mode field cannot leave 01 except through reset;
- a blocked device-disable write leaves the register unchanged;
- an unblocked write loads the write data;
- read data always mirrors the addressed register.

The bench scenarios cover what needs a chosen sequence:
- the exact cycle at which a pin edge starts to block writes, through the synchronizer;
- each of the three resets releasing a locked mode field on its own;
- the mode value 11, which blocks writes but does not lock the field;
- unmapped addresses.

// File: rtl/guard_reg_pkg.sv
// Package: shared constants and types for the lockable device-disable block.
// Assumes the mode field sits at bits [3:2] of an 8-bit configuration word.
package guard_reg_pkg;
    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 8;
    localparam int MODE_LSB = 2;
    localparam int MODE_W   = 2;
    localparam logic [MODE_W-1:0] GUARD_CODE = 2'b01;

    typedef logic [DATA_W-1:0] reg_word_t;
    typedef logic [ADDR_W-1:0] reg_addr_t;
endpackage

// File: rtl/guard_pin_sync.sv
// Module: multi-stage synchronizer for the asynchronous guard pin.
// Assumes: STAGES >= 1; the reset value of every stage is 0 (pin treated low).
module guard_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic pin_sync
);
    logic [STAGES-1:0] chain_q;

    // Shift the pin level through the flop chain.
    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= pin_async;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], pin_async};
            end
        end
    endgenerate

    assign pin_sync = chain_q[STAGES-1];
endmodule

// File: rtl/guard_cfg_reg.sv
// Module: pin configuration register with a mode field that locks itself.
// Assumes: wr_en is already address-decoded. Once the mode field holds the
// guard code, only the reset can clear it; the other bits stay writable.
module guard_cfg_reg
    import guard_reg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  reg_word_t wr_data,
    output reg_word_t cfg_q,
    output logic      mode_locked
);
    reg_word_t cfg_nxt;

    // Flag whether the mode field currently holds the guard code.
    always_comb begin
        mode_locked = (cfg_q[MODE_LSB+MODE_W-1:MODE_LSB] == GUARD_CODE);
    end

    // Merge the write data with the field held by the lock.
    always_comb begin
        cfg_nxt = wr_data;
        if (mode_locked) begin
            cfg_nxt[MODE_LSB+MODE_W-1:MODE_LSB] = GUARD_CODE;
        end
    end

    // Hold the configuration word.
    always_ff @(posedge clk) begin
        if (!rst_n)     cfg_q <= '0;
        else if (wr_en) cfg_q <= cfg_nxt;
    end
endmodule

// File: rtl/guard_dd_reg.sv
// Module: device-disable register whose writes can be suppressed.
// Assumes: wr_en is already address-decoded; wr_block is settled before the edge.
module guard_dd_reg
    import guard_reg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  logic      wr_block,
    input  reg_word_t wr_data,
    output reg_word_t dd_q
);
    // Load the register on an accepted write only.
    always_ff @(posedge clk) begin
        if (!rst_n)                     dd_q <= '0;
        else if (wr_en && !wr_block)    dd_q <= wr_data;
    end
endmodule

// File: rtl/guard_reg_ctrl.sv
// Module: top of the lockable device-disable register control.
// Decodes the register port, merges the three synchronous resets and forms
// the write-block term from configuration bit 2 and the synchronized pin.
// Assumes: all resets are synchronous to clk; guard_pin may be asynchronous.
module guard_reg_ctrl
    import guard_reg_pkg::*;
#(
    parameter logic [7:0] DD_ADDR     = 8'h22,
    parameter logic [7:0] CFG_ADDR    = 8'h30,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       stby_por_n,
    input  logic       hard_rst_n,
    input  logic [7:0] addr,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       guard_pin
);
    logic      rst_all_n;
    logic      pin_s;
    logic      sel_dd;
    logic      sel_cfg;
    logic      dd_block;
    logic      mode_locked;
    reg_word_t cfg_q;
    reg_word_t dd_q;

    // Combine the three reset sources; any one clears the block.
    always_comb begin
        rst_all_n = por_n & stby_por_n & hard_rst_n;
    end

    // Decode the register address.
    always_comb begin
        sel_dd  = (addr == DD_ADDR);
        sel_cfg = (addr == CFG_ADDR);
    end

    // Block device-disable writes when bit 2 is set and the pin reads high.
    always_comb begin
        dd_block = cfg_q[MODE_LSB] & pin_s;
    end

    guard_pin_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk       (clk),
        .rst_n     (rst_all_n),
        .pin_async (guard_pin),
        .pin_sync  (pin_s)
    );

    guard_cfg_reg cfg_i (
        .clk         (clk),
        .rst_n       (rst_all_n),
        .wr_en       (wr_en & sel_cfg),
        .wr_data     (wr_data),
        .cfg_q       (cfg_q),
        .mode_locked (mode_locked)
    );

    guard_dd_reg dd_i (
        .clk      (clk),
        .rst_n    (rst_all_n),
        .wr_en    (wr_en & sel_dd),
        .wr_block (dd_block),
        .wr_data  (wr_data),
        .dd_q     (dd_q)
    );

    // Return the addressed register, zero elsewhere.
    always_comb begin
        if (sel_dd)       rd_data = dd_q;
        else if (sel_cfg) rd_data = cfg_q;
        else              rd_data = '0;
    end
endmodule

// File: rtl/guard_reg_ctrl_chk.sv
// Checker: temporal rules of the lockable device-disable block.
// Assumes it is bound into guard_reg_ctrl and sees its internal state.
module guard_reg_ctrl_chk #(
    parameter logic [7:0] DD_ADDR  = 8'h22,
    parameter logic [7:0] CFG_ADDR = 8'h30
) (
    input logic       clk,
    input logic       rst_all_n,
    input logic [7:0] addr,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic [7:0] cfg_q,
    input logic [7:0] dd_q,
    input logic       pin_s
);
    // R1: a reset cycle leaves both registers cleared.
    assert_reset_clear_R1: assert property (@(posedge clk)
        (!rst_all_n) |=> (dd_q == 8'h00 && cfg_q == 8'h00));

    // R2: the guard code in the mode field survives every non-reset cycle.
    assert_mode_sticky_R2: assert property (@(posedge clk) disable iff (!rst_all_n)
        (cfg_q[3:2] == 2'b01) |=> (cfg_q[3:2] == 2'b01));

    // R4: a blocked write leaves the device-disable register unchanged.
    assert_blocked_hold_R4: assert property (@(posedge clk) disable iff (!rst_all_n)
        (wr_en && addr == DD_ADDR && cfg_q[2] && pin_s) |=> $stable(dd_q));

    // R5: an unblocked write loads the data.
    assert_open_write_R5: assert property (@(posedge clk) disable iff (!rst_all_n)
        (wr_en && addr == DD_ADDR && !(cfg_q[2] && pin_s)) |=> (dd_q == $past(wr_data)));

    // R6: read data mirrors the addressed register.
    assert_read_dd_R6: assert property (@(posedge clk) disable iff (!rst_all_n)
        (addr == DD_ADDR) |-> (rd_data == dd_q));
    assert_read_cfg_R6: assert property (@(posedge clk) disable iff (!rst_all_n)
        (addr == CFG_ADDR) |-> (rd_data == cfg_q));
endmodule

bind guard_reg_ctrl guard_reg_ctrl_chk #(
    .DD_ADDR  (DD_ADDR),
    .CFG_ADDR (CFG_ADDR)
) chk_i (
    .clk       (clk),
    .rst_all_n (rst_all_n),
    .addr      (addr),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .cfg_q     (cfg_q),
    .dd_q      (dd_q),
    .pin_s     (pin_s)
);

// File: tb/guard_reg_ctrl_tb.sv
// Scoreboard bench: read tasks queue expected values, a monitor compares them.
module guard_reg_ctrl_tb_top;
    localparam logic [7:0] DD  = 8'h22;
    localparam logic [7:0] CFG = 8'h30;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       stby_por_n = 1'b1;
    logic       hard_rst_n = 1'b1;
    logic [7:0] addr = 8'h00;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       guard_pin = 1'b0;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;
    logic rd_req = 1'b0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } sb_item_t;
    sb_item_t sb_q[$];

    // Bench model of the registers, computed from the requirements.
    logic [7:0] dd_m = 8'h00;
    logic [7:0] cfg_m = 8'h00;
    logic       pin_eff = 1'b0;

    always #2 clk = ~clk;

    guard_reg_ctrl dut_i (
        .clk        (clk),
        .por_n      (por_n),
        .stby_por_n (stby_por_n),
        .hard_rst_n (hard_rst_n),
        .addr       (addr),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .guard_pin  (guard_pin)
    );

    // Monitor: compare each queued read at the falling edge.
    always @(negedge clk) begin
        if (rd_req && sb_q.size() > 0) begin
            sb_item_t it;
            it = sb_q.pop_front();
            checks++;
            if (rd_data !== it.exp) begin
                errors++;
                $display("FAIL %s: rd_data=%02h expected=%02h", it.tag, rd_data, it.exp);
            end
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d, input logic pin_seen);
        @(posedge clk); #1;
        addr = a; wr_data = d; wr_en = 1'b1;
        if (a == DD) begin
            if (!(cfg_m[2] && pin_seen)) dd_m = d;
        end else if (a == CFG) begin
            if (cfg_m[3:2] == 2'b01) cfg_m = {d[7:4], 2'b01, d[1:0]};
            else                     cfg_m = d;
        end
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] a, input logic [7:0] exp, input string tag);
        sb_item_t it;
        @(posedge clk); #1;
        addr = a;
        it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        rd_req = 1'b1;
        @(posedge clk); #1;
        rd_req = 1'b0;
    endtask

    task automatic set_pin(input logic v);
        guard_pin = v;
        idle(3);
        pin_eff = v;
    endtask

    task automatic pulse_reset(input int which);
        @(posedge clk); #1;
        case (which)
            0: por_n = 1'b0;
            1: stby_por_n = 1'b0;
            default: hard_rst_n = 1'b0;
        endcase
        idle(2);
        por_n = 1'b1; stby_por_n = 1'b1; hard_rst_n = 1'b1;
        dd_m = 8'h00; cfg_m = 8'h00;
        idle(3);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        for (int i = 0; i < 100000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        por_n = 1'b1;
        idle(3);
        // R1: reset state of both registers
        do_read(DD,  8'h00, "R1 dd after power-on");
        do_read(CFG, 8'h00, "R1 cfg after power-on");

        // R5: mode 00 with pin high, writes accepted
        set_pin(1'b1);
        do_write(DD, 8'hA5, pin_eff);
        do_read(DD, dd_m, "R5 dd write with bit2 clear");

        // R3: full config write outside guard mode
        do_write(CFG, 8'hF3, pin_eff);
        do_read(CFG, 8'hF3, "R3 cfg full write");

        // R3/R4: mode 11 blocks but does not lock
        do_write(CFG, 8'h0C, pin_eff);
        do_write(DD, 8'h11, pin_eff);
        do_read(DD, 8'hA5, "R4 mode 11 pin high blocks");
        do_write(CFG, 8'h00, pin_eff);
        do_read(CFG, 8'h00, "R3 mode 11 clears by write");

        // R2: enter guard mode and try to leave it
        set_pin(1'b0);
        do_write(CFG, 8'h05, pin_eff);
        do_write(CFG, 8'h00, pin_eff);
        do_read(CFG, 8'h04, "R2 field kept, bit0 cleared");
        do_write(CFG, 8'hF8, pin_eff);
        do_read(CFG, 8'hF4, "R2 upper bits written, field kept");

        // R5: guard mode, pin low, writes accepted
        do_write(DD, 8'h3C, pin_eff);
        do_read(DD, 8'h3C, "R5 guard pin low write");

        // R7: write right after the pin rises still sees old low level
        @(posedge clk); #1;
        guard_pin = 1'b1;
        do_write(DD, 8'h77, 1'b0);
        do_read(DD, 8'h77, "R7 synchronizer latency");
        idle(3);
        pin_eff = 1'b1;

        // R4/R6: blocked write, read still shows current value
        do_write(DD, 8'h99, pin_eff);
        do_read(DD, 8'h77, "R4 R6 blocked write readback");

        // R6: unmapped address reads zero, its write changes nothing
        do_write(8'h40, 8'hFF, pin_eff);
        do_read(8'h40, 8'h00, "R6 unmapped read");
        do_read(CFG, 8'hF4, "R6 cfg unchanged by unmapped write");

        // R1: each reset source releases the lock
        pulse_reset(2);
        do_read(CFG, 8'h00, "R1 hard reset clears cfg");
        do_read(DD, 8'h00, "R1 hard reset clears dd");
        do_write(CFG, 8'h04, pin_eff);
        do_write(DD, 8'h5A, pin_eff);
        pulse_reset(1);
        do_read(CFG, 8'h00, "R1 standby reset clears cfg");
        do_read(DD, 8'h00, "R1 standby reset clears dd");
        do_write(CFG, 8'h04, pin_eff);
        pulse_reset(0);
        do_read(CFG, 8'h00, "R1 main reset clears cfg");

        // R5: after reset, mode 10 (bit2 clear) with pin high stays writable
        do_write(CFG, 8'h08, pin_eff);
        do_write(DD, 8'hC3, pin_eff);
        do_read(DD, 8'hC3, "R5 mode 10 pin high write");

        idle(2);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule